// File: doc/BRIEF.md
# Two-Channel Wiper Command Target (I2C)

This block is the serial front end of a two-channel digital potentiometer controller. It listens on an I2C bus (serial clock in, serial data in, and an open-drain pull-down enable for data out), recognises start and stop conditions, and answers to a 7-bit address whose two low bits come from strap pins. The upper five bits are a build parameter. Bus lines are brought into the system clock domain through a synchroniser and then edge-detected, so the bus rate must be well below the system clock.

In a write frame, the byte after the address is an instruction that carries a channel select and three control flags. Every data byte after it produces a one-cycle command strobe to the control core. The strobe carries the flags and the byte, so a single frame can move a wiper many times. A read frame has no instruction. The target returns the wiper byte of the channel named by the last accepted instruction, then a verify byte built from the two programming status inputs. It keeps alternating the two bytes for as long as the controller acknowledges.

Top module: `dpot_i2c_target`

## Requirements
- R1: After reset the data line is released, no strobe is issued, and a read returns the channel-0 wiper (`wiper_a`).
- R2: The target acknowledges an address byte whose upper seven bits equal {ADDR_HI, addr_pin}, by pulling data low during the ninth clock. Bit 0 is the direction: 0 = write, 1 = read.
- R3: An address that does not match gets no acknowledge, and the target neither drives the line nor strobes until the next start.
- R4: Instruction byte decoding: bit 7 = channel (0 = `wiper_a`, 1 = `wiper_b`), bit 6 = shutdown, bit 5 = permanent program, bit 3 = override. Bits 2..0 are ignored. Every strobe presents these fields as latched from the frame's instruction.
- R5: Each data byte in a write frame is acknowledged and produces exactly one single-cycle strobe carrying that byte. Any number of data bytes may follow one instruction.
- R6: An instruction byte with bit 4 set is acknowledged but discarded. No strobe follows for any data byte of that frame, and the read channel stays as it was.
- R7: A read frame's first byte is the selected wiper value, sent most significant bit first.
- R8: The byte after the wiper byte is the verify byte {E1, E0, 000000}, with E1 = `otp_flags[1]` and E0 = `otp_flags[0]`.
- R9: While the controller acknowledges, the read continues by alternating the wiper byte and the verify byte.
- R10: The target changes the data line only while the clock is low. It releases the line after a controller not-acknowledge and after any stop.
- R11: A repeated start at any point abandons the current frame and decodes a fresh address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus serial clock |
| sda_i | input | 1 | Bus serial data as seen on the wire |
| sda_oe | output | 1 | 1 = pull the data line low |
| addr_pin | input | 2 | Strapped low address bits |
| wiper_a | input | 8 | Current wiper value of channel 0 |
| wiper_b | input | 8 | Current wiper value of channel 1 |
| otp_flags | input | 2 | Programming status, [1] = E1, [0] = E0 |
| cmd_stb | output | 1 | One-cycle command strobe per data byte |
| cmd_chan | output | 1 | Channel of the command |
| cmd_shdn | output | 1 | Shutdown flag |
| cmd_prog | output | 1 | Permanent program flag |
| cmd_ovr | output | 1 | Override flag |
| cmd_data | output | 8 | Wiper data byte |

## Verification
The last data byte's strobe and the decoding of a new frame can fall together. This happens when a repeated start follows a data byte's acknowledge directly: the strobe is still settling while the line monitor reports the new start. The bench provokes this by issuing a write with one data byte, then a repeated start with a read address and no stop between them. It judges the result in three ways: exactly one strobe with the right byte and channel, an acknowledged read address, and a wiper byte from the channel that the abandoned write frame had just selected.

// File: rtl/dpot_i2c_pkg.sv
package dpot_i2c_pkg;
  localparam int BYTE_W  = 8;
  localparam int IB_CHAN = 7;
  localparam int IB_SHDN = 6;
  localparam int IB_PROG = 5;
  localparam int IB_RSVD = 4;
  localparam int IB_OVR  = 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_RX_END, ST_ACK_OUT, ST_TX, ST_ACK_IN
  } fsm_t;

  typedef enum logic [1:0] {
    PH_ADDR, PH_INSTR, PH_DATA, PH_READ
  } phase_t;

  typedef struct packed {
    logic chan;
    logic shdn;
    logic prog;
    logic ovr;
  } instr_t;
endpackage

// File: rtl/dpot_i2c_linemon.sv
module dpot_i2c_linemon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0][1:0] stg;
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg   <= '1;
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      stg   <= {stg[SYNC_STAGES-2:0], {scl_i, sda_i}};
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_s     = stg[SYNC_STAGES-1][1];
  assign sda_s     = stg[SYNC_STAGES-1][0];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/dpot_i2c_frame.sv
module dpot_i2c_frame
  import dpot_i2c_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_s,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [6:0]        dev_addr,
  input  logic [BYTE_W-1:0] wiper_a,
  input  logic [BYTE_W-1:0] wiper_b,
  input  logic [1:0]        otp_flags,
  output logic              sda_oe,
  output logic              cmd_stb,
  output instr_t            cmd,
  output logic [BYTE_W-1:0] cmd_data
);
  localparam int CNT_W = $clog2(BYTE_W);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

  fsm_t              state;
  phase_t            phase;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] shreg, txreg;
  logic              tx_vfy, rd_chan, cur_ok, ack_in;
  instr_t            cur;

  logic [BYTE_W-1:0] wiper_sel, vfy_byte, next_tx;
  assign wiper_sel = rd_chan ? wiper_b : wiper_a;
  assign vfy_byte  = {otp_flags, {(BYTE_W-2){1'b0}}};
  assign next_tx   = tx_vfy ? vfy_byte : wiper_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      phase    <= PH_ADDR;
      cnt      <= '0;
      shreg    <= '0;
      txreg    <= '0;
      tx_vfy   <= 1'b0;
      rd_chan  <= 1'b0;
      cur_ok   <= 1'b0;
      ack_in   <= 1'b0;
      cur      <= '0;
      sda_oe   <= 1'b0;
      cmd_stb  <= 1'b0;
      cmd      <= '0;
      cmd_data <= '0;
    end else begin
      cmd_stb <= 1'b0;
      if (start_det) begin
        state  <= ST_RX;
        phase  <= PH_ADDR;
        cnt    <= '0;
        sda_oe <= 1'b0;
      end else if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        case (state)
          ST_RX: if (scl_rise) begin
            shreg <= {shreg[BYTE_W-2:0], sda_s};
            cnt   <= cnt + 1'b1;
            if (cnt == LAST_BIT) state <= ST_RX_END;
          end
          ST_RX_END: if (scl_fall) begin
            state  <= ST_ACK_OUT;
            sda_oe <= 1'b1;
            case (phase)
              PH_ADDR: begin
                if (shreg[BYTE_W-1:1] == dev_addr) begin
                  phase <= shreg[0] ? PH_READ : PH_INSTR;
                end else begin
                  state  <= ST_IDLE;
                  sda_oe <= 1'b0;
                end
              end
              PH_INSTR: begin
                phase  <= PH_DATA;
                cur_ok <= ~shreg[IB_RSVD];
                if (!shreg[IB_RSVD]) begin
                  cur.chan <= shreg[IB_CHAN];
                  cur.shdn <= shreg[IB_SHDN];
                  cur.prog <= shreg[IB_PROG];
                  cur.ovr  <= shreg[IB_OVR];
                  rd_chan  <= shreg[IB_CHAN];
                end
              end
              default: begin
                if (cur_ok) begin
                  cmd_stb  <= 1'b1;
                  cmd      <= cur;
                  cmd_data <= shreg;
                end
              end
            endcase
          end
          ST_ACK_OUT: if (scl_fall) begin
            cnt <= '0;
            if (phase == PH_READ) begin
              txreg  <= wiper_sel;
              sda_oe <= ~wiper_sel[BYTE_W-1];
              tx_vfy <= 1'b1;
              state  <= ST_TX;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_RX;
            end
          end
          ST_TX: if (scl_fall) begin
            cnt <= cnt + 1'b1;
            if (cnt == LAST_BIT) begin
              sda_oe <= 1'b0;
              state  <= ST_ACK_IN;
            end else begin
              txreg  <= {txreg[BYTE_W-2:0], 1'b0};
              sda_oe <= ~txreg[BYTE_W-2];
            end
          end
          ST_ACK_IN: begin
            if (scl_rise) ack_in <= ~sda_s;
            if (scl_fall) begin
              if (ack_in) begin
                txreg  <= next_tx;
                sda_oe <= ~next_tx[BYTE_W-1];
                tx_vfy <= ~tx_vfy;
                cnt    <= '0;
                state  <= ST_TX;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/dpot_i2c_target.sv
module dpot_i2c_target
  import dpot_i2c_pkg::*;
#(
  parameter logic [4:0] ADDR_HI     = 5'b01011,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [1:0] addr_pin,
  input  logic [7:0] wiper_a,
  input  logic [7:0] wiper_b,
  input  logic [1:0] otp_flags,
  output logic       cmd_stb,
  output logic       cmd_chan,
  output logic       cmd_shdn,
  output logic       cmd_prog,
  output logic       cmd_ovr,
  output logic [7:0] cmd_data
);
  logic   scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  instr_t cmd;

  dpot_i2c_linemon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  dpot_i2c_frame u_frame (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det),
    .dev_addr({ADDR_HI, addr_pin}), .wiper_a(wiper_a), .wiper_b(wiper_b),
    .otp_flags(otp_flags), .sda_oe(sda_oe), .cmd_stb(cmd_stb),
    .cmd(cmd), .cmd_data(cmd_data)
  );

  assign cmd_chan = cmd.chan;
  assign cmd_shdn = cmd.shdn;
  assign cmd_prog = cmd.prog;
  assign cmd_ovr  = cmd.ovr;
endmodule

// File: rtl/dpot_i2c_chk.sv
module dpot_i2c_chk (
  input logic clk,
  input logic rst,
  input logic scl_s,
  input logic start_det,
  input logic stop_det,
  input logic sda_oe,
  input logic cmd_stb
);
  AST_RST_QUIET: assert property (@(posedge clk)
    rst |=> (!sda_oe && !cmd_stb)); // R1
  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (rst)
    cmd_stb |=> !cmd_stb); // R5
  AST_STB_ACKED: assert property (@(posedge clk) disable iff (rst)
    cmd_stb |-> sda_oe); // R5
  AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !$past(scl_s)); // R10
  AST_STOP_FREE: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe); // R10
  AST_START_FREE: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (!sda_oe && !cmd_stb)); // R11
endmodule

bind dpot_i2c_target dpot_i2c_chk u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .sda_oe(sda_oe), .cmd_stb(cmd_stb)
);

// File: tb/sim_dpot_i2c_target.sv
module sim_dpot_i2c_target;
  localparam int Q = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bm_scl = 1'b1;
  logic       bm_sda = 1'b1;
  logic       sda_oe;
  logic [1:0] addr_pin = 2'b10;
  logic [7:0] wiper_a = 8'h96;
  logic [7:0] wiper_b = 8'h5B;
  logic [1:0] otp_flags = 2'b10;
  logic       cmd_stb, cmd_chan, cmd_shdn, cmd_prog, cmd_ovr;
  logic [7:0] cmd_data;
  wire        sda_bus = bm_sda & ~sda_oe;

  int nchk = 0;
  int nerr = 0;
  int stb_cnt = 0;
  logic [11:0] stb_last = '0;

  always #4 clk = ~clk;

  dpot_i2c_target u0 (
    .clk(clk), .rst(rst), .scl_i(bm_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .addr_pin(addr_pin), .wiper_a(wiper_a), .wiper_b(wiper_b),
    .otp_flags(otp_flags), .cmd_stb(cmd_stb), .cmd_chan(cmd_chan),
    .cmd_shdn(cmd_shdn), .cmd_prog(cmd_prog), .cmd_ovr(cmd_ovr),
    .cmd_data(cmd_data)
  );

  always @(negedge clk) begin
    if (!rst && cmd_stb) begin
      stb_cnt  <= stb_cnt + 1;
      stb_last <= {cmd_chan, cmd_shdn, cmd_prog, cmd_ovr, cmd_data};
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    bm_sda = 1'b1; wq();
    bm_scl = 1'b1; wq();
    bm_sda = 1'b0; wq();
    bm_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    bm_sda = 1'b0; wq();
    bm_scl = 1'b1; wq();
    bm_sda = 1'b1; wq();
  endtask

  task automatic bus_bit(input logic b, output logic r);
    bm_sda = b; wq();
    bm_scl = 1'b1; wq();
    r = sda_bus; wq();
    bm_scl = 1'b0; wq();
  endtask

  task automatic wr_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], r);
    bus_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic rd_byte(input logic ack, output logic [7:0] d);
    logic r;
    d = '0;
    for (int i = 7; i >= 0; i--) begin
      bus_bit(1'b1, r);
      d[i] = r;
    end
    bus_bit(~ack, r);
  endtask

  task automatic t_reset();
    logic a; logic [7:0] d;
    chk("R1 sda released", sda_oe, 0);
    chk("R1 no strobe", stb_cnt, 0);
    bus_start();
    wr_byte(8'h5D, a);
    chk("R2 read address ack", a, 1);
    rd_byte(1'b0, d);
    chk("R1 reset channel 0 wiper", d, 8'h96);
    bus_stop();
  endtask

  task automatic t_write_burst();
    logic a; int base = stb_cnt;
    bus_start();
    wr_byte(8'h5C, a); chk("R2 write address ack", a, 1);
    wr_byte(8'hCD, a); chk("R4 instruction ack", a, 1);
    wr_byte(8'h3A, a); chk("R5 data ack", a, 1);
    chk("R5 first strobe data", stb_last, {4'b1101, 8'h3A});
    wr_byte(8'hF1, a);
    wr_byte(8'h07, a); chk("R5 last data ack", a, 1);
    bus_stop();
    chk("R5 one strobe per byte", stb_cnt - base, 3);
    chk("R4 flags chan=1 shdn=1 prog=0 ovr=1", stb_last, {4'b1101, 8'h07});
    chk("R10 released after stop", sda_oe, 0);
  endtask

  task automatic t_read_cycle();
    logic a; logic [7:0] d;
    bus_start();
    wr_byte(8'h5D, a); chk("R2 read ack", a, 1);
    rd_byte(1'b1, d); chk("R7 wiper of channel 1", d, 8'h5B);
    rd_byte(1'b1, d); chk("R8 verify byte E1=1 E0=0", d, 8'h80);
    rd_byte(1'b0, d); chk("R9 wiper repeats", d, 8'h5B);
    chk("R10 released after nack", sda_oe, 0);
    bus_stop();
  endtask

  task automatic t_wrong_addr();
    logic a; int base = stb_cnt;
    bus_start();
    wr_byte(8'h5A, a); chk("R3 no ack on mismatch", a, 0);
    wr_byte(8'h00, a); chk("R3 instruction ignored", a, 0);
    wr_byte(8'h55, a); chk("R3 data ignored", a, 0);
    bus_stop();
    chk("R3 no strobe", stb_cnt - base, 0);
  endtask

  task automatic t_reserved();
    logic a; logic [7:0] d; int base = stb_cnt;
    bus_start();
    wr_byte(8'h5C, a);
    wr_byte(8'h17, a); chk("R6 reserved instruction acked", a, 1);
    wr_byte(8'h44, a); chk("R6 data acked", a, 1);
    bus_stop();
    chk("R6 no strobe", stb_cnt - base, 0);
    bus_start();
    wr_byte(8'h5D, a);
    rd_byte(1'b0, d); chk("R6 read channel kept", d, 8'h5B);
    bus_stop();
  endtask

  task automatic t_restart();
    logic a; logic [7:0] d; int base = stb_cnt;
    bus_start();
    wr_byte(8'h5C, a);
    wr_byte(8'h00, a);
    wr_byte(8'h21, a);
    bus_start();
    wr_byte(8'h5D, a); chk("R11 address after restart acked", a, 1);
    rd_byte(1'b0, d); chk("R11 read follows new channel 0", d, 8'h96);
    bus_stop();
    chk("R11 single strobe before restart", stb_cnt - base, 1);
    chk("R4 all flags clear", stb_last, {4'b0000, 8'h21});
  endtask

  task automatic t_program_flag();
    logic a; logic [7:0] d;
    otp_flags = 2'b11;
    wiper_b = 8'hE4;
    bus_start();
    wr_byte(8'h5C, a);
    wr_byte(8'hA2, a);
    wr_byte(8'hFF, a);
    bus_stop();
    chk("R4 program flag", stb_last, {4'b1010, 8'hFF});
    bus_start();
    wr_byte(8'h5D, a);
    rd_byte(1'b1, d); chk("R7 wiper channel 1", d, 8'hE4);
    rd_byte(1'b0, d); chk("R8 verify E1=1 E0=1", d, 8'hC0);
    bus_stop();
  endtask

  task automatic t_pins();
    logic a;
    addr_pin = 2'b01;
    bus_start();
    wr_byte(8'h5C, a); chk("R3 old address now ignored", a, 0);
    bus_stop();
    bus_start();
    wr_byte(8'h5A, a); chk("R2 strap address acked", a, 1);
    bus_stop();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    t_reset();
    t_write_burst();
    t_read_cycle();
    t_wrong_addr();
    t_reserved();
    t_restart();
    t_program_flag();
    t_pins();
    repeat (20) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    nchk++;
    nerr++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end
endmodule